// File: doc/BRIEF.md
# Clock-Independent Host Access Port for a Bin Memory

This block lets a microprocessor read and write any entry of a 1024-entry, 24-bit bin memory without sharing the memory clock. The host drives a 10-bit address and two active-low strobes, one for writes and one for reads. Each strobe goes through a two-flop synchronizer, and the memory access takes place on the synchronized falling edge. The result of a read stays on the bus until the next read. The data bus is split at the pad into an input, an output and an output enable. It carries either a full 24-bit word or a 16-bit slice. For the 16-bit slice, an upper-word select picks the slice. A 16-bit write merges into the stored word and leaves the other part of the entry unchanged.

The memory is shared with a clocked processing engine. A host access takes the memory cycle in which it lands, and the engine's grant drops for that one cycle. Outside host mode, the write strobe is ignored. The read strobe then only enables the bus driver, which carries the engine's output word.

Top module: `hostmem_port`

## Requirements
- R1: A host access lands on the third rising clock edge after its strobe falls. The memory index is the value on `hst_addr` at that edge, so the host holds the address and data stable for at least four clock periods while the strobe is low.
- R2: In 24-bit mode (`bus16`=0), a host write stores all of `dio_i[23:0]`, and a later host read returns that word on `dio_o[23:0]`.
- R3: In 16-bit mode with `hst_uws`=1, a host write stores `dio_i[7:0]` into entry bits 23:16. Entry bits 15:0 keep their previous value.
- R4: In 16-bit mode with `hst_uws`=0, a host write stores `dio_i[15:0]` into entry bits 15:0. Entry bits 23:16 keep their previous value.
- R5: In a 16-bit host read with `hst_uws`=1, `dio_o[7:0]` carries entry bits 23:16 and `dio_o[23:8]` is zero. With `hst_uws`=0, `dio_o[15:0]` carries entry bits 15:0 and `dio_o[23:16]` is zero.
- R6: While `host_mode`=0, a write strobe leaves the memory unchanged.
- R7: While `host_mode`=0, a low `hst_rd_n` drives `eng_dout` onto `dio_o` with `dio_oe`=1. No memory access takes place.
- R8: In 24-bit mode, `hst_uws` has no effect on writes or reads.
- R9: A host read result stays on `dio_o` while `hst_rd_n` is low, even if the address changes. It changes only at the next read access.
- R10: Each strobe fall gives exactly one access cycle, during which `eng_gnt` is 0. In every other cycle, `eng_gnt` is 1. A granted engine write updates the entry at the clock edge. A granted engine read puts the entry on `eng_rdata` after one clock edge.
- R11: `dio_oe` is 0 whenever `hst_rd_n` is high.
- R12: During reset, `dio_oe`=0, `eng_gnt`=1 and `eng_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host access modes active |
| bus16 | input | 1 | 1 = 16-bit bus, 0 = 24-bit bus |
| hst_addr | input | 10 | Host entry index |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_rd_n | input | 1 | Host read strobe / output enable, active low |
| hst_uws | input | 1 | Upper-slice select for 16-bit mode |
| dio_i | input | 24 | Bus value from the pads |
| dio_o | output | 24 | Bus value to the pads |
| dio_oe | output | 1 | Pad driver enable |
| eng_dout | input | 24 | Engine output word for the bus |
| eng_req | input | 1 | Engine memory request |
| eng_we | input | 1 | Engine request is a write |
| eng_addr | input | 10 | Engine entry index |
| eng_wdata | input | 24 | Engine write word |
| eng_gnt | output | 1 | Engine request accepted this cycle |
| eng_rdata | output | 24 | Engine read word, one cycle after grant |

## Verification
A table of writes runs in both bus widths and with both slice selects, at the lowest, highest and alternating-bit addresses. Every write is read back as a full 24-bit word, so a wrong slice merge shows up as a corrupted neighbouring field. In 16-bit reads, the upper-lane data is chosen to differ from the lower-lane data, so a swapped or unzeroed lane is caught. Directed cases cover the following: a write strobe outside host mode, the bus under the engine, read-data hold while the address moves, and counting of grant-denied cycles under contention. Engine writes are read back by the host, which confirms that both ports see the same storage.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,
    LANE_LOW  = 2'd1,
    LANE_HIGH = 2'd2
  } lane_e;
endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], strb_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_pulse = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/hmp_lane_fmt.sv
module hmp_lane_fmt
  import hmp_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input  hmp_pkg::lane_e    lane,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] merged
);
  localparam int UPPER_W = DATA_W - NARROW_W;

  always_comb begin
    bus_out = rd_word;
    merged  = bus_in;
    unique case (lane)
      LANE_LOW: begin
        bus_out = {{UPPER_W{1'b0}}, rd_word[NARROW_W-1:0]};
        merged  = {old_word[DATA_W-1:NARROW_W], bus_in[NARROW_W-1:0]};
      end
      LANE_HIGH: begin
        bus_out = {{NARROW_W{1'b0}}, rd_word[DATA_W-1:NARROW_W]};
        merged  = {bus_in[UPPER_W-1:0], old_word[NARROW_W-1:0]};
      end
      default: begin
        bus_out = rd_word;
        merged  = bus_in;
      end
    endcase
  end
endmodule

// File: rtl/hmp_bank_arb.sv
module hmp_bank_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rword,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_gnt,
  output logic [DATA_W-1:0] eng_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              erd_en;
  logic [DATA_W-1:0] erd_d;

  assign host_rword = bank[host_addr];
  assign eng_gnt    = ~host_busy;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = host_addr;
    wr_data = host_wdata;
    if (host_we) begin
      wr_en = 1'b1;
    end else if (eng_req && eng_we && !host_busy) begin
      wr_en   = 1'b1;
      wr_addr = eng_addr;
      wr_data = eng_wdata;
    end
    erd_en = eng_req && !eng_we && !host_busy;
    erd_d  = bank[eng_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_rdata <= '0;
    end else if (erd_en) begin
      eng_rdata <= erd_d;
    end
  end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 24,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              bus16,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_wr_n,
  input  logic              hst_rd_n,
  input  logic              hst_uws,
  input  logic [DATA_W-1:0] dio_i,
  output logic [DATA_W-1:0] dio_o,
  output logic              dio_oe,
  input  logic [DATA_W-1:0] eng_dout,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_gnt,
  output logic [DATA_W-1:0] eng_rdata
);
  localparam int NSTROBE = 2;

  logic [NSTROBE-1:0] strb_n;
  logic [NSTROBE-1:0] strb_fall;
  logic               wr_pulse;
  logic               rd_pulse;
  logic               host_we;
  logic               host_busy;
  lane_e              lane;
  logic [DATA_W-1:0]  old_word;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  host_bus;
  logic [DATA_W-1:0]  rd_hold;
  logic [DATA_W-1:0]  rd_hold_d;
  logic               rd_hold_en;

  assign strb_n = {hst_rd_n, hst_wr_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_n     (strb_n[g]),
      .fall_pulse (strb_fall[g])
    );
  end

  assign wr_pulse = strb_fall[0];
  assign rd_pulse = strb_fall[1];

  always_comb begin
    if (!bus16)       lane = LANE_FULL;
    else if (hst_uws) lane = LANE_HIGH;
    else              lane = LANE_LOW;
    host_we    = host_mode & wr_pulse;
    host_busy  = host_mode & (wr_pulse | rd_pulse);
    rd_hold_en = host_mode & rd_pulse;
    rd_hold_d  = old_word;
  end

  hmp_lane_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_fmt (
    .lane     (lane),
    .rd_word  (rd_hold),
    .old_word (old_word),
    .bus_in   (dio_i),
    .bus_out  (host_bus),
    .merged   (merged)
  );

  hmp_bank_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_busy  (host_busy),
    .host_we    (host_we),
    .host_addr  (hst_addr),
    .host_wdata (merged),
    .host_rword (old_word),
    .eng_req    (eng_req),
    .eng_we     (eng_we),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .eng_gnt    (eng_gnt),
    .eng_rdata  (eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold <= '0;
    end else if (rd_hold_en) begin
      rd_hold <= rd_hold_d;
    end
  end

  assign dio_o  = host_mode ? host_bus : eng_dout;
  assign dio_oe = ~hst_rd_n;
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              bus16,
  input logic              hst_wr_n,
  input logic              hst_rd_n,
  input logic              wr_pulse,
  input logic              rd_pulse,
  input logic [DATA_W-1:0] rd_hold,
  input logic [DATA_W-1:0] dio_o,
  input logic              dio_oe,
  input logic [DATA_W-1:0] eng_dout,
  input logic              eng_gnt
);
  a_r1_fall_seen_before: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !$past(hst_wr_n, 2));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && (wr_pulse || rd_pulse)) |-> !eng_gnt);

  a_r9_hold_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_hold) |-> $past(rd_pulse));

  a_r7_engine_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !hst_rd_n) |-> (dio_o == eng_dout && dio_oe));

  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && bus16 && !hst_rd_n) |-> (dio_o[DATA_W-1:NARROW_W] == '0));
endmodule

bind hostmem_port hmp_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_mode (host_mode),
  .bus16     (bus16),
  .hst_wr_n  (hst_wr_n),
  .hst_rd_n  (hst_rd_n),
  .wr_pulse  (wr_pulse),
  .rd_pulse  (rd_pulse),
  .rd_hold   (rd_hold),
  .dio_o     (dio_o),
  .dio_oe    (dio_oe),
  .eng_dout  (eng_dout),
  .eng_gnt   (eng_gnt)
);

// File: tb/tb_hostmem_port.sv
module tb_hostmem_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_mode, bus16, hst_wr_n, hst_rd_n, hst_uws;
  logic [9:0]  hst_addr, eng_addr;
  logic [23:0] dio_i, dio_o, eng_dout, eng_wdata, eng_rdata;
  logic        dio_oe, eng_req, eng_we, eng_gnt;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hostmem_port dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .bus16(bus16),
    .hst_addr(hst_addr), .hst_wr_n(hst_wr_n), .hst_rd_n(hst_rd_n),
    .hst_uws(hst_uws), .dio_i(dio_i), .dio_o(dio_o), .dio_oe(dio_oe),
    .eng_dout(eng_dout), .eng_req(eng_req), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_gnt(eng_gnt),
    .eng_rdata(eng_rdata)
  );

  // {bus16, uws, addr[9:0], write data[23:0], expected full word[23:0]}
  localparam logic [59:0] VEC [8] = '{
    {1'b0, 1'b0, 10'h000, 24'hA5C3F1, 24'hA5C3F1},
    {1'b0, 1'b0, 10'h3FF, 24'h123456, 24'h123456},
    {1'b1, 1'b1, 10'h3FF, 24'hFFFF9E, 24'h9E3456},
    {1'b1, 1'b0, 10'h000, 24'hEE7788, 24'hA57788},
    {1'b0, 1'b1, 10'h155, 24'h0F0F0F, 24'h0F0F0F},
    {1'b0, 1'b0, 10'h2AA, 24'hF0F0F0, 24'hF0F0F0},
    {1'b1, 1'b1, 10'h155, 24'h000001, 24'h010F0F},
    {1'b1, 1'b0, 10'h2AA, 24'hFFBEEF, 24'hF0BEEF}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [9:0] a, input logic [23:0] d,
                            input logic b16, input logic u);
    @(negedge clk);
    bus16 = b16; hst_uws = u; hst_addr = a; dio_i = d; hst_wr_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    hst_wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // leaves the read strobe low; caller releases it
  task automatic host_read_start(input logic [9:0] a, input logic b16, input logic u,
                                 output logic [23:0] v);
    @(negedge clk);
    host_mode = 1'b1; bus16 = b16; hst_uws = u; hst_addr = a; hst_rd_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    v = dio_o;
  endtask

  task automatic host_read(input logic [9:0] a, input logic b16, input logic u,
                           output logic [23:0] v);
    host_read_start(a, b16, u, v);
    hst_rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [23:0] v2;
    int          denied;
    rst_n = 1'b0; host_mode = 1'b1; bus16 = 1'b0; hst_wr_n = 1'b1; hst_rd_n = 1'b1;
    hst_uws = 1'b0; hst_addr = '0; dio_i = '0; eng_dout = '0; eng_req = 1'b0;
    eng_we = 1'b0; eng_addr = '0; eng_wdata = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 oe", {23'd0, dio_oe}, 24'd0);
    check("R12 gnt", {23'd0, eng_gnt}, 24'd1);
    check("R12 rdata", eng_rdata, 24'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R8: table of writes, each read back as a full word
    for (int i = 0; i < 8; i++) begin
      host_write(VEC[i][57:48], VEC[i][47:24], VEC[i][59], VEC[i][58]);
      host_read(VEC[i][57:48], 1'b0, ~VEC[i][58], v);
      check($sformatf("R1/R2/R3/R4/R8 vec%0d", i), v, VEC[i][23:0]);
    end

    // R5 narrow reads of 0x3FF = 9E3456
    host_read(10'h3FF, 1'b1, 1'b1, v);
    check("R5 upper slice", v, 24'h00009E);
    host_read(10'h3FF, 1'b1, 1'b0, v);
    check("R5 lower slice", v, 24'h003456);

    // R9 hold while address moves, then R11 tri-state after release
    host_read_start(10'h155, 1'b0, 1'b0, v);
    check("R9 first", v, 24'h010F0F);
    hst_addr = 10'h2AA;
    repeat (4) @(negedge clk);
    check("R9 held", dio_o, 24'h010F0F);
    check("R11 oe while low", {23'd0, dio_oe}, 24'd1);
    hst_rd_n = 1'b1;
    #1;
    check("R11 oe released", {23'd0, dio_oe}, 24'd0);
    repeat (3) @(negedge clk);

    // R6 write strobe outside host mode is ignored
    host_mode = 1'b0;
    host_write(10'h000, 24'h111111, 1'b0, 1'b0);
    host_read(10'h000, 1'b0, 1'b0, v);
    check("R6 no write", v, 24'hA57788);

    // R7 engine bus outside host mode
    @(negedge clk);
    host_mode = 1'b0; eng_dout = 24'hABCDEF; hst_rd_n = 1'b0;
    @(negedge clk);
    check("R7 bus", dio_o, 24'hABCDEF);
    check("R7 oe", {23'd0, dio_oe}, 24'd1);
    repeat (4) @(negedge clk);
    hst_rd_n = 1'b1;
    @(negedge clk);
    check("R11 oe engine mode", {23'd0, dio_oe}, 24'd0);
    host_read(10'h3FF, 1'b0, 1'b0, v);
    check("R7 no access", v, 24'h9E3456);

    // R10 engine write then host read, engine read
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = 10'h0AB; eng_wdata = 24'h765432;
    @(negedge clk);
    eng_req = 1'b0; eng_we = 1'b0;
    host_read(10'h0AB, 1'b0, 1'b0, v);
    check("R10 engine write seen", v, 24'h765432);
    @(negedge clk);
    eng_req = 1'b1; eng_addr = 10'h3FF;
    @(negedge clk);
    eng_req = 1'b0;
    check("R10 engine read", eng_rdata, 24'h9E3456);

    // R10 contention: one denied cycle per host strobe fall
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b0; eng_addr = 10'h000;
    bus16 = 1'b0; hst_addr = 10'h1C3; dio_i = 24'h5A5A5A; hst_wr_n = 1'b0;
    denied = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!eng_gnt) denied++;
    end
    hst_wr_n = 1'b1;
    eng_req = 1'b0;
    check("R10 denied cycles", denied[23:0], 24'd1);
    repeat (3) @(negedge clk);
    host_read(10'h1C3, 1'b0, 1'b0, v2);
    check("R10 host write under contention", v2, 24'h5A5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule